// File: doc/BRIEF.md
# Rotary Encoder Tuning Step Controller

This block sits at the front of a receiver's tuning path. It follows a two-phase Gray-code rotary knob and a step push button, both already debounced. It holds the receive frequency in hertz as a 32-bit unsigned number. Each valid knob detent moves the frequency up or down by the current step size. Each press of the button moves on to the next step size in a fixed cyclic list. The frequency is always held inside the supported tuning window.

The block also gives the local-oscillator frequency, which is four times the receive frequency, because the sampling detector splits its oscillator into four quarter-period phases. A one-cycle strobe tells a downstream synthesizer configurator that a new value is ready. Inputs are sampled on every clock. A result appears on the outputs one clock after the edge that sees the input change.

Top module: `tune_step_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `rx_freq_hz` = 500000, `step_hz` = 1000 and `lo_update` = 0. A button held high through the release of reset does not count as a press.
- R2: Knob codes {enc_a,enc_b} run through positions 0..3 as 00, 01, 11, 10. A change to the next position (3 wraps to 0) raises `rx_freq_hz` by `step_hz`. The new value is visible in the cycle after the clock edge that samples the new code.
- R3: A change to the previous position (0 wraps to 3) lowers `rx_freq_hz` by `step_hz`, with the same one-cycle latency as R2.
- R4: A change in which both code bits flip at once leaves `rx_freq_hz` unchanged and produces no `lo_update`. The new code becomes the reference for the next transition.
- R5: A rising edge on `step_btn` selects the next entry of the step list 10, 50, 1000, 10000, 100000 Hz. Holding the button high does not advance the step again.
- R6: Pressing the button while the step is 100000 Hz selects 10 Hz.
- R7: An increment that would take the frequency above 17000000 leaves it at exactly 17000000.
- R8: A decrement that would take the frequency below 500000 leaves it at exactly 500000.
- R9: `lo_update` is high for exactly those cycles in which `rx_freq_hz` differs from its value in the previous cycle.
- R10: `lo_freq_hz` always equals four times `rx_freq_hz`.
- R11: When a detent and a button press are sampled on the same edge, the frequency moves by the step that was in force before the press. The new step applies from the next detent on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Knob phase A (code MSB) |
| enc_b | input | 1 | Knob phase B (code LSB) |
| step_btn | input | 1 | Step-select button, high when pressed |
| rx_freq_hz | output | 32 | Receive frequency in hertz |
| lo_freq_hz | output | 32 | Local-oscillator frequency, four times the receive frequency |
| lo_update | output | 1 | One-cycle strobe when the frequency has changed |
| step_hz | output | 32 | Current tuning step in hertz |

## Verification
A knob detent and a button edge can both be sampled on the same clock edge. The frequency adder then has to use the step register's old value while that register advances. The bench provokes this by driving a Gray transition and a press rising edge in the same cycle. It does this at several step positions, including the wrap from the largest step to the smallest. It judges the result by checking that the frequency moved by the old step while `step_hz` already shows the new one. Detents can also coincide with saturation at either end of the window. In that case the bench expects the clamped value and no strobe once the limit is held.

// File: rtl/tune_pkg.sv
package tune_pkg;

   localparam int unsigned STEP_COUNT = 5;
   localparam int unsigned STEP_IDX_W = $clog2(STEP_COUNT);

   typedef enum logic [1:0] {
      MOVE_NONE = 2'd0,
      MOVE_UP   = 2'd1,
      MOVE_DOWN = 2'd2,
      MOVE_BAD  = 2'd3
   } move_e;

   // position of a knob code along the forward rotation order
   function automatic logic [1:0] code_pos(input logic [1:0] code);
      case (code)
         2'b00:   code_pos = 2'd0;
         2'b01:   code_pos = 2'd1;
         2'b11:   code_pos = 2'd2;
         default: code_pos = 2'd3;
      endcase
   endfunction

   // tuning step size in hertz for a list index
   function automatic logic [31:0] step_size(input logic [STEP_IDX_W-1:0] idx);
      case (idx)
         3'd0:    step_size = 32'd10;
         3'd1:    step_size = 32'd50;
         3'd2:    step_size = 32'd1000;
         3'd3:    step_size = 32'd10000;
         3'd4:    step_size = 32'd100000;
         default: step_size = 32'd10;
      endcase
   endfunction

endpackage

// File: rtl/tune_gray_dec.sv
module tune_gray_dec
   import tune_pkg::*;
#(
   parameter bit REVERSE = 1'b0
) (
   input  logic  clk,
   input  logic  enc_a,
   input  logic  enc_b,
   output move_e move
);

   logic [1:0] code_now;
   logic [1:0] code_q;
   logic [1:0] diff;

   assign code_now = {enc_a, enc_b};

   // reference code tracks the knob on every edge, also during reset
   always_ff @(posedge clk) begin
      code_q <= code_now;
   end

   assign diff = code_pos(code_now) - code_pos(code_q);

   if (REVERSE) begin : g_rev
      always_comb begin
         case (diff)
            2'd1:    move = MOVE_DOWN;
            2'd3:    move = MOVE_UP;
            2'd2:    move = MOVE_BAD;
            default: move = MOVE_NONE;
         endcase
      end
   end else begin : g_fwd
      always_comb begin
         case (diff)
            2'd1:    move = MOVE_UP;
            2'd3:    move = MOVE_DOWN;
            2'd2:    move = MOVE_BAD;
            default: move = MOVE_NONE;
         endcase
      end
   end

endmodule

// File: rtl/tune_step_sel.sv
module tune_step_sel
   import tune_pkg::*;
#(
   parameter int unsigned W         = 32,
   parameter int unsigned RESET_IDX = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  btn,
   output logic                  press,
   output logic [STEP_IDX_W-1:0] idx,
   output logic [W-1:0]          step
);

   localparam logic [STEP_IDX_W-1:0] LAST_IDX = STEP_IDX_W'(STEP_COUNT - 1);
   localparam logic [STEP_IDX_W-1:0] INIT_IDX = STEP_IDX_W'(RESET_IDX);

   if (RESET_IDX >= STEP_COUNT) begin : g_bad_reset_idx
      $error("tune_step_sel: RESET_IDX outside the step list");
   end

   logic btn_q;

   always_ff @(posedge clk) begin
      btn_q <= btn;
   end

   assign press = btn & ~btn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= INIT_IDX;
      end else if (press) begin
         idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
   end

   assign step = W'(step_size(idx));

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (press && idx == LAST_IDX) |=> (idx == '0)); // R6

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !press |=> $stable(idx)); // R5

endmodule

// File: rtl/tune_freq_acc.sv
module tune_freq_acc
   import tune_pkg::*;
#(
   parameter int unsigned    W       = 32,
   parameter logic [W-1:0]   F_MIN   = W'(500_000),
   parameter logic [W-1:0]   F_MAX   = W'(17_000_000),
   parameter logic [W-1:0]   F_RESET = W'(500_000)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  move_e        move,
   input  logic [W-1:0] step,
   output logic [W-1:0] freq,
   output logic         update
);

   logic [W:0]   sum_up;
   logic [W:0]   floor_dn;
   logic [W-1:0] freq_nxt;

   assign sum_up   = {1'b0, freq} + {1'b0, step};
   assign floor_dn = {1'b0, F_MIN} + {1'b0, step};

   always_comb begin
      case (move)
         MOVE_UP:   freq_nxt = (sum_up > {1'b0, F_MAX}) ? F_MAX : sum_up[W-1:0];
         MOVE_DOWN: freq_nxt = ({1'b0, freq} < floor_dn) ? F_MIN : freq - step;
         default:   freq_nxt = freq;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freq   <= F_RESET;
         update <= 1'b0;
      end else begin
         freq   <= freq_nxt;
         update <= (freq_nxt != freq);
      end
   end

   AST_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      freq <= F_MAX); // R7

   AST_NOT_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      freq >= F_MIN); // R8

   AST_UPDATE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      update |-> (freq != $past(freq))); // R9

   AST_CHANGE_MEANS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      (freq != $past(freq)) |-> update); // R9

   AST_DOWN_NEVER_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MOVE_DOWN) |=> (freq <= $past(freq))); // R3

endmodule

// File: rtl/tune_step_ctrl.sv
module tune_step_ctrl
   import tune_pkg::*;
#(
   parameter int unsigned  W           = 32,
   parameter logic [W-1:0] F_MIN       = W'(500_000),
   parameter logic [W-1:0] F_MAX       = W'(17_000_000),
   parameter logic [W-1:0] F_RESET     = W'(500_000),
   parameter int unsigned  RESET_STEP  = 2,
   parameter bit           ENC_REVERSE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         enc_a,
   input  logic         enc_b,
   input  logic         step_btn,
   output logic [W-1:0] rx_freq_hz,
   output logic [W-1:0] lo_freq_hz,
   output logic         lo_update,
   output logic [W-1:0] step_hz
);

   localparam int unsigned LO_SHIFT = 2;

   if (W < 24) begin : g_bad_width
      $error("tune_step_ctrl: W too small for the step list");
   end
   if (F_MIN >= F_MAX) begin : g_bad_window
      $error("tune_step_ctrl: F_MIN must lie below F_MAX");
   end
   if (F_RESET < F_MIN || F_RESET > F_MAX) begin : g_bad_reset
      $error("tune_step_ctrl: F_RESET outside the tuning window");
   end
   if (F_MAX[W-1 -: LO_SHIFT] != '0) begin : g_bad_lo
      $error("tune_step_ctrl: F_MAX times four overflows W bits");
   end

   move_e                 move;
   logic                  press;
   logic [STEP_IDX_W-1:0] step_idx;

   tune_gray_dec #(
      .REVERSE (ENC_REVERSE)
   ) u_dec (
      .clk   (clk),
      .enc_a (enc_a),
      .enc_b (enc_b),
      .move  (move)
   );

   tune_step_sel #(
      .W         (W),
      .RESET_IDX (RESET_STEP)
   ) u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .btn   (step_btn),
      .press (press),
      .idx   (step_idx),
      .step  (step_hz)
   );

   tune_freq_acc #(
      .W       (W),
      .F_MIN   (F_MIN),
      .F_MAX   (F_MAX),
      .F_RESET (F_RESET)
   ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .move   (move),
      .step   (step_hz),
      .freq   (rx_freq_hz),
      .update (lo_update)
   );

   assign lo_freq_hz = rx_freq_hz << LO_SHIFT;

   AST_BAD_JUMP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MOVE_BAD) |=> ($stable(rx_freq_hz) && !lo_update)); // R4

   AST_OLD_STEP_ON_PRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (press && move == MOVE_UP && ({1'b0, rx_freq_hz} + {1'b0, step_hz} <= {1'b0, F_MAX}))
      |=> (rx_freq_hz == $past(rx_freq_hz) + $past(step_hz))); // R11

endmodule

// File: tb/tune_step_ctrl_bench.sv
module tune_step_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam longint FMIN = 500000;
   localparam longint FMAX = 17000000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enc_a = 1'b0;
   logic        enc_b = 1'b0;
   logic        step_btn = 1'b0;
   logic [31:0] rx_freq_hz;
   logic [31:0] lo_freq_hz;
   logic        lo_update;
   logic [31:0] step_hz;

   int checks = 0;
   int failures = 0;

   // bench model state
   longint m_rx = FMIN;
   int     m_idx = 2;
   logic [1:0] m_ab = 2'b00;
   logic   m_btn = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tune_step_ctrl u_tune_step_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .enc_a      (enc_a),
      .enc_b      (enc_b),
      .step_btn   (step_btn),
      .rx_freq_hz (rx_freq_hz),
      .lo_freq_hz (lo_freq_hz),
      .lo_update  (lo_update),
      .step_hz    (step_hz)
   );

   function automatic longint step_of(input int i);
      case (i)
         0: return 10;
         1: return 50;
         2: return 1000;
         3: return 10000;
         default: return 100000;
      endcase
   endfunction

   function automatic logic [1:0] code_of(input int p);
      case (p & 3)
         0: return 2'b00;
         1: return 2'b01;
         2: return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   function automatic int pos_of(input logic [1:0] c);
      case (c)
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock: drive inputs, model the edge, compare after it
   task automatic cycle(input logic [1:0] ab, input logic btn);
      int     d;
      longint nrx;
      longint stp;
      logic   prs;
      logic   wrapped;
      string  tag;
      @(negedge clk);
      enc_a = ab[1];
      enc_b = ab[0];
      step_btn = btn;
      d   = (pos_of(ab) - pos_of(m_ab)) & 3;
      stp = step_of(m_idx);
      prs = btn & ~m_btn;
      nrx = m_rx;
      tag = "R9";
      if (d == 1) begin
         if (m_rx + stp > FMAX) begin nrx = FMAX; tag = "R7"; end
         else begin nrx = m_rx + stp; tag = "R2"; end
      end else if (d == 3) begin
         if (m_rx < FMIN + stp) begin nrx = FMIN; tag = "R8"; end
         else begin nrx = m_rx - stp; tag = "R3"; end
      end else if (d == 2) begin
         tag = "R4";
      end
      if (prs && (d == 1 || d == 3)) tag = "R11";
      wrapped = 1'b0;
      if (prs) begin
         if (m_idx == 4) begin m_idx = 0; wrapped = 1'b1; end
         else m_idx = m_idx + 1;
      end
      @(posedge clk);
      #1;
      check(tag, longint'(rx_freq_hz), nrx);
      check("R9", longint'(lo_update), (nrx != m_rx) ? 1 : 0);
      check("R10", longint'(lo_freq_hz), nrx * 4);
      check(wrapped ? "R6" : "R5", longint'(step_hz), step_of(m_idx));
      m_rx  = nrx;
      m_ab  = ab;
      m_btn = btn;
   endtask

   task automatic detents(input int n, input bit up);
      for (int k = 0; k < n; k++) begin
         cycle(code_of(pos_of(m_ab) + (up ? 1 : 3)), 1'b0);
      end
   endtask

   task automatic press_once();
      cycle(m_ab, 1'b1);
      cycle(m_ab, 1'b0);
   endtask

   task automatic select_step(input int target);
      while (m_idx != target) press_once();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset with the button held through release
      step_btn = 1'b1;
      m_btn = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1", longint'(rx_freq_hz), FMIN);
      check("R1", longint'(step_hz), 1000);
      check("R1", longint'(lo_update), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cycle(2'b00, 1'b1);
      check("R1", longint'(step_hz), 1000);
      cycle(2'b00, 1'b0);

      // every step size: forward and reverse detents, with wrap
      for (int s = 0; s < 6; s++) begin
         detents(3, 1'b1);
         detents(2, 1'b0);
         press_once();
      end

      // exhaustive code pair sweep (legal, illegal and idle)
      for (int p = 0; p < 4; p++) begin
         for (int n = 0; n < 4; n++) begin
            cycle(code_of(p), 1'b0);
            cycle(code_of(n), 1'b0);
         end
      end

      // button held for several cycles advances once
      cycle(m_ab, 1'b1);
      cycle(m_ab, 1'b1);
      cycle(m_ab, 1'b1);
      cycle(m_ab, 1'b0);

      // coincident press and detent at every step, both directions
      for (int s = 0; s < 5; s++) begin
         cycle(code_of(pos_of(m_ab) + 1), 1'b1);
         cycle(code_of(pos_of(m_ab) + 3), 1'b0);
         cycle(code_of(pos_of(m_ab) + 3), 1'b1);
         cycle(m_ab, 1'b0);
      end

      // run into the upper limit with the largest step
      select_step(4);
      detents(170, 1'b1);
      select_step(3);
      detents(3, 1'b1);
      cycle(code_of(pos_of(m_ab) + 1), 1'b1);
      cycle(m_ab, 1'b0);

      // run into the lower limit
      select_step(4);
      detents(170, 1'b0);
      select_step(1);
      detents(1, 1'b1);
      detents(3, 1'b0);
      select_step(0);
      detents(2, 1'b0);
      detents(4, 1'b1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule